// File: doc/BRIEF.md
# TDM Serial Audio Transmitter Framer

This block turns parallel audio words into a time-division-multiplexed serial stream on up to `NLINES` data lines at once. A single bit-rate strobe from an external divider paces it. Each strobe is one half of a bit period, and from the strobes the block makes its own serial clock. The block counts bits and slots. It shapes the frame sync and places every word inside its slot, MSB first. A narrow word is set to the left or the right end of the slot, and the unused bits are sent as zeros.

One framer serves every common audio layout. The sync can be one bit wide or one slot wide, it can lead the data by one bit, and both the sync and the clock can be inverted. With these controls the same block produces I2S, left-justified, right-justified and both DSP variants.

A per-slot mask and a per-line enable decide which slots and lines carry data. Network mode sends several slots per frame. Normal mode sends a single word per frame.

Words come from a small holding interface. At the start of every enabled slot the framer takes one word per line. If no word is offered, it flags an underrun, sends zeros and keeps the frame timing unchanged. Configuration is sampled only as a frame begins. Until the first frame, the block holds a two-slot, 32-bit layout.

Top module: `tdm_tx_framer`

## Requirements
- R1: While reset is high and on the first clock after it, `sck_o`, `fs_o`, `sd_o`, `sd_oe_o`, `word_take_o`, `underrun_o`, `last_slot_o` and `even_slot_o` are all 0. The first bit sent after reset is bit 0 of slot 0 of a new frame.
- R2: Every clock with `bit_en` high toggles an internal phase. `sck_o` equals that phase XOR the frame's clock-invert bit, and after reset the phase starts at 0. `sd_o`, `sd_oe_o` and `fs_o` change only on a strobe that returns the phase to 0. On every other clock they hold their value.
- R3: All configuration inputs are sampled when a frame's first bit is sent. In network mode a frame is `cfg_slots_i` slots (legal values 1..32). In normal mode a frame is one slot. Each slot is `cfg_slot_w_i` bits (2..32), so frame sync pulses repeat every slots × width bits.
- R4: With `cfg_fs_word_i`=1 the sync is active for all bits of slot 0. With 0 it is active only for bit 0 of slot 0.
- R5: With `cfg_fs_early_i`=1 the sync pattern moves one bit earlier. The bit that R4 would mark last in the frame is dropped, and the last bit of the preceding frame, sent under that frame's settings, becomes active instead.
- R6: With `cfg_fs_inv_i`=1 the sync is active low: `fs_o` is the active level XOR this bit.
- R7: Line L takes its word from bits [L*32 +: 32] of `word_data_i`, with the value in the low `cfg_word_w_i` bits. A word width above the slot width counts as the slot width. With `cfg_right_i`=0 the word's MSB is bit 0 of the slot, bits follow MSB first, and the rest of the slot is zero.
- R8: With `cfg_right_i`=1 the slot starts with zeros, and the word's LSB is the slot's last bit.
- R9: Bit s of `cfg_slot_mask_i` enables slot s (bit 0 in normal mode). In a masked slot every `sd_oe_o` and `sd_o` bit is 0, and neither `word_take_o` nor `underrun_o` pulses.
- R10: `sd_oe_o[L]` is 1 exactly during enabled slots of frames with `cfg_line_en_i[L]`=1. While `sd_oe_o[L]` is 0, `sd_o[L]` is 0.
- R11: At the first bit of an enabled slot, `word_take_o` pulses for one clock if `word_valid_i` was high, and that word is sent. Otherwise `underrun_o` pulses for one clock, the slot is sent as zeros, and the timing is unchanged.
- R12: `last_slot_o` pulses for one clock when the first bit of the frame's last slot is sent. `even_slot_o` is 1 while an even-numbered slot (counting from 0) is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Half-bit strobe from the clock divider |
| cfg_slots_i | input | 6 | Slots per frame in network mode |
| cfg_slot_w_i | input | 6 | Bits per slot |
| cfg_word_w_i | input | 6 | Valid bits per word |
| cfg_network_i | input | 1 | 1 network mode, 0 normal (one slot) |
| cfg_fs_word_i | input | 1 | 1 sync lasts one slot, 0 one bit |
| cfg_fs_early_i | input | 1 | Sync leads the data by one bit |
| cfg_fs_inv_i | input | 1 | Active-low frame sync |
| cfg_sck_inv_i | input | 1 | Inverted serial clock |
| cfg_right_i | input | 1 | Right-align the word in its slot |
| cfg_slot_mask_i | input | 32 | Per-slot enable |
| cfg_line_en_i | input | NLINES | Per-line enable |
| word_valid_i | input | 1 | A word set is offered |
| word_data_i | input | NLINES*32 | One word per line |
| word_take_o | output | 1 | Offered words consumed |
| sck_o | output | 1 | Serial bit clock |
| fs_o | output | 1 | Frame sync |
| sd_o | output | NLINES | Serial data lines |
| sd_oe_o | output | NLINES | Per-line drive enable |
| underrun_o | output | 1 | Enabled slot started with no word |
| last_slot_o | output | 1 | Last slot of the frame begins |
| even_slot_o | output | 1 | Even-numbered slot in progress |

## Verification
Every output is a register. The clock edge that sees `bit_en` high updates `sck_o` and, on a phase-0 strobe, the data, enable, sync and pulse outputs, so the bench samples all of them at the falling edge right after that strobe edge. It samples again on later idle clocks to confirm that the pulses lasted one clock and that the lines held. Configuration and words are driven at a falling edge before the strobe. The model applies configuration at the same frame boundary as the design, so expected values for a given bit come from the inputs present on that bit's strobe.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int MAX_W     = 32;
    localparam int MAX_SLOTS = 32;
    localparam int LEN_W     = $clog2(MAX_W + 1);
    localparam int BIT_IW    = $clog2(MAX_W);
    localparam int SCNT_W    = $clog2(MAX_SLOTS + 1);
    localparam int SLOT_IW   = $clog2(MAX_SLOTS);

    typedef struct packed {
        logic [SCNT_W-1:0]    slots;
        logic [LEN_W-1:0]     slot_w;
        logic [LEN_W-1:0]     word_w;
        logic                 network;
        logic                 fs_word;
        logic                 fs_early;
        logic                 fs_inv;
        logic                 sck_inv;
        logic                 right_al;
        logic [MAX_SLOTS-1:0] mask;
    } tdm_cfg_t;

    function automatic tdm_cfg_t cfg_reset();
        tdm_cfg_t c;
        c.slots    = SCNT_W'(2);
        c.slot_w   = LEN_W'(MAX_W);
        c.word_w   = LEN_W'(MAX_W);
        c.network  = 1'b1;
        c.fs_word  = 1'b1;
        c.fs_early = 1'b0;
        c.fs_inv   = 1'b0;
        c.sck_inv  = 1'b0;
        c.right_al = 1'b0;
        c.mask     = '1;
        return c;
    endfunction

    function automatic tdm_cfg_t cfg_normalize(tdm_cfg_t c);
        tdm_cfg_t r = c;
        if (r.word_w > r.slot_w) r.word_w = r.slot_w;
        if (!r.network)          r.slots  = SCNT_W'(1);
        return r;
    endfunction

    // bit b (0 = first sent) of a slot holding word w
    function automatic logic slot_bit(logic [MAX_W-1:0] w, logic [BIT_IW-1:0] b,
                                      logic [LEN_W-1:0] sw, logic [LEN_W-1:0] ww,
                                      logic right_al);
        int bi = int'(b);
        int s  = int'(sw);
        int n  = int'(ww);
        int idx;
        logic [BIT_IW-1:0] sel;
        if (right_al) begin
            if (bi < s - n) return 1'b0;
            idx = s - 1 - bi;
        end else begin
            if (bi >= n) return 1'b0;
            idx = n - 1 - bi;
        end
        sel = BIT_IW'(idx);
        return w[sel];
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
    import tdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  tdm_cfg_t           cfg_in,
    output logic               adv,
    output logic               phase_q,
    output logic               frame_start,
    output logic               slot_load,
    output logic [SLOT_IW-1:0] nxt_slot,
    output logic [BIT_IW-1:0]  nxt_bit,
    output tdm_cfg_t           cfg_eff,
    output tdm_cfg_t           cfg_q
);
    logic [SLOT_IW-1:0] slot_q;
    logic [BIT_IW-1:0]  bit_q;
    logic               last_bit, last_slot;

    assign last_bit    = (LEN_W'(bit_q) == cfg_q.slot_w - LEN_W'(1));
    assign last_slot   = (SCNT_W'(slot_q) == cfg_q.slots - SCNT_W'(1));
    assign adv         = bit_en & phase_q;
    assign frame_start = adv & last_bit & last_slot;
    assign slot_load   = adv & last_bit;
    assign cfg_eff     = frame_start ? cfg_normalize(cfg_in) : cfg_q;

    always_comb begin
        if (last_bit) begin
            nxt_bit  = '0;
            nxt_slot = last_slot ? '0 : slot_q + SLOT_IW'(1);
        end else begin
            nxt_bit  = bit_q + BIT_IW'(1);
            nxt_slot = slot_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            slot_q  <= SLOT_IW'(1);
            bit_q   <= BIT_IW'(MAX_W - 1);
            cfg_q   <= cfg_reset();
        end else if (bit_en) begin
            phase_q <= ~phase_q;
            if (adv) begin
                slot_q <= nxt_slot;
                bit_q  <= nxt_bit;
                cfg_q  <= cfg_eff;
            end
        end
    end

endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
    import tdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [SLOT_IW-1:0] nxt_slot,
    input  logic [BIT_IW-1:0]  nxt_bit,
    input  tdm_cfg_t           cfg_eff,
    output logic               fs_o
);
    logic at_end, in_first, at_first, active;

    assign at_end   = (SCNT_W'(nxt_slot) == cfg_eff.slots - SCNT_W'(1)) &&
                      (LEN_W'(nxt_bit) == cfg_eff.slot_w - LEN_W'(1));
    assign in_first = (nxt_slot == '0);
    assign at_first = in_first && (nxt_bit == '0);

    always_comb begin
        if (cfg_eff.fs_early)
            active = at_end || (cfg_eff.fs_word && in_first &&
                                (LEN_W'(nxt_bit) < cfg_eff.slot_w - LEN_W'(1)));
        else
            active = cfg_eff.fs_word ? in_first : at_first;
    end

    always_ff @(posedge clk) begin
        if (rst)      fs_o <= 1'b0;
        else if (adv) fs_o <= active ^ cfg_eff.fs_inv;
    end

    AST_FS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(fs_o)); // R2

endmodule

// File: rtl/tdm_lane_bank.sv
module tdm_lane_bank
    import tdm_pkg::*;
#(
    parameter int NLINES = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    input  logic                    slot_load,
    input  logic                    frame_start,
    input  logic                    slot_active,
    input  logic                    word_valid,
    input  logic [NLINES*MAX_W-1:0] word_data,
    input  logic [NLINES-1:0]       line_en_in,
    input  logic [BIT_IW-1:0]       nxt_bit,
    input  tdm_cfg_t                cfg_eff,
    output logic [NLINES-1:0]       sd_o,
    output logic [NLINES-1:0]       oe_o
);
    logic [NLINES-1:0] line_en_q, line_en_eff;
    logic              act_q, act_nxt;

    assign line_en_eff = frame_start ? line_en_in : line_en_q;
    assign act_nxt     = slot_load ? slot_active : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_en_q <= '0;
            act_q     <= 1'b0;
        end else if (adv) begin
            line_en_q <= line_en_eff;
            act_q     <= act_nxt;
        end
    end

    for (genvar l = 0; l < NLINES; l++) begin : g_lane
        logic [MAX_W-1:0] word_q, word_nxt;
        logic             oe_nxt;

        always_comb begin
            word_nxt = word_q;
            if (slot_load)
                word_nxt = (slot_active && word_valid) ? word_data[l*MAX_W +: MAX_W] : '0;
        end
        assign oe_nxt = act_nxt & line_en_eff[l];

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q  <= '0;
                sd_o[l] <= 1'b0;
                oe_o[l] <= 1'b0;
            end else if (adv) begin
                word_q  <= word_nxt;
                oe_o[l] <= oe_nxt;
                sd_o[l] <= oe_nxt & slot_bit(word_nxt, nxt_bit, cfg_eff.slot_w,
                                             cfg_eff.word_w, cfg_eff.right_al);
            end
        end

        AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
            !oe_o[l] |-> !sd_o[l]); // R10
    end

endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
    import tdm_pkg::*;
#(
    parameter int NLINES = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic [SCNT_W-1:0]       cfg_slots_i,
    input  logic [LEN_W-1:0]        cfg_slot_w_i,
    input  logic [LEN_W-1:0]        cfg_word_w_i,
    input  logic                    cfg_network_i,
    input  logic                    cfg_fs_word_i,
    input  logic                    cfg_fs_early_i,
    input  logic                    cfg_fs_inv_i,
    input  logic                    cfg_sck_inv_i,
    input  logic                    cfg_right_i,
    input  logic [MAX_SLOTS-1:0]    cfg_slot_mask_i,
    input  logic [NLINES-1:0]       cfg_line_en_i,
    input  logic                    word_valid_i,
    input  logic [NLINES*MAX_W-1:0] word_data_i,
    output logic                    word_take_o,
    output logic                    sck_o,
    output logic                    fs_o,
    output logic [NLINES-1:0]       sd_o,
    output logic [NLINES-1:0]       sd_oe_o,
    output logic                    underrun_o,
    output logic                    last_slot_o,
    output logic                    even_slot_o
);
    tdm_cfg_t           cfg_in, cfg_eff, cfg_q;
    logic               adv, phase_q, frame_start, slot_load, slot_active;
    logic [SLOT_IW-1:0] nxt_slot;
    logic [BIT_IW-1:0]  nxt_bit;

    assign cfg_in = '{slots: cfg_slots_i, slot_w: cfg_slot_w_i, word_w: cfg_word_w_i,
                      network: cfg_network_i, fs_word: cfg_fs_word_i,
                      fs_early: cfg_fs_early_i, fs_inv: cfg_fs_inv_i,
                      sck_inv: cfg_sck_inv_i, right_al: cfg_right_i,
                      mask: cfg_slot_mask_i};

    tdm_slot_timer u_timer (
        .clk(clk), .rst(rst), .bit_en(bit_en), .cfg_in(cfg_in), .adv(adv),
        .phase_q(phase_q), .frame_start(frame_start), .slot_load(slot_load),
        .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .cfg_eff(cfg_eff), .cfg_q(cfg_q)
    );

    tdm_fsync_gen u_fsync (
        .clk(clk), .rst(rst), .adv(adv), .nxt_slot(nxt_slot), .nxt_bit(nxt_bit),
        .cfg_eff(cfg_eff), .fs_o(fs_o)
    );

    assign slot_active = cfg_eff.mask[nxt_slot];

    tdm_lane_bank #(.NLINES(NLINES)) u_lanes (
        .clk(clk), .rst(rst), .adv(adv), .slot_load(slot_load),
        .frame_start(frame_start), .slot_active(slot_active),
        .word_valid(word_valid_i), .word_data(word_data_i),
        .line_en_in(cfg_line_en_i), .nxt_bit(nxt_bit), .cfg_eff(cfg_eff),
        .sd_o(sd_o), .oe_o(sd_oe_o)
    );

    assign sck_o = phase_q ^ cfg_q.sck_inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_take_o <= 1'b0;
            underrun_o  <= 1'b0;
            last_slot_o <= 1'b0;
            even_slot_o <= 1'b0;
        end else begin
            word_take_o <= slot_load & slot_active & word_valid_i;
            underrun_o  <= slot_load & slot_active & ~word_valid_i;
            last_slot_o <= slot_load & (SCNT_W'(nxt_slot) == cfg_eff.slots - SCNT_W'(1));
            if (adv) even_slot_o <= ~nxt_slot[0];
        end
    end

    AST_TAKE_XOR_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        !(word_take_o && underrun_o)); // R11
    AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        word_take_o |-> $past(word_valid_i)); // R11
    AST_LAST_SLOT_PULSE: assert property (@(posedge clk) disable iff (rst)
        last_slot_o |=> !last_slot_o); // R12
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(sd_o) && $stable(sd_oe_o)); // R2

endmodule

// File: tb/tdm_tx_framer_tb_top.sv
module tdm_tx_framer_tb_top;
    localparam int NL = 6;
    localparam int W  = 32;

    logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0;
    logic [5:0] cfg_slots, cfg_sw, cfg_ww;
    logic cfg_net, cfg_fsw, cfg_early, cfg_inv, cfg_sckinv, cfg_right;
    logic [31:0] cfg_mask;
    logic [NL-1:0] cfg_lines;
    logic word_valid;
    logic [NL*W-1:0] word_data;
    logic take, sck, fs, under, last, even;
    logic [NL-1:0] sd, oe;

    tdm_tx_framer #(.NLINES(NL)) dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .cfg_slots_i(cfg_slots),
        .cfg_slot_w_i(cfg_sw), .cfg_word_w_i(cfg_ww), .cfg_network_i(cfg_net),
        .cfg_fs_word_i(cfg_fsw), .cfg_fs_early_i(cfg_early), .cfg_fs_inv_i(cfg_inv),
        .cfg_sck_inv_i(cfg_sckinv), .cfg_right_i(cfg_right), .cfg_slot_mask_i(cfg_mask),
        .cfg_line_en_i(cfg_lines), .word_valid_i(word_valid), .word_data_i(word_data),
        .word_take_o(take), .sck_o(sck), .fs_o(fs), .sd_o(sd), .sd_oe_o(oe),
        .underrun_o(under), .last_slot_o(last), .even_slot_o(even)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    int m_pos = 63, m_len = 64, m_sw = 32, m_ww = 32, m_slots = 2;
    bit m_phase = 0, m_fsw = 1, m_early = 0, m_inv = 0, m_sckinv = 0, m_right = 0, m_act = 0;
    logic [31:0] m_mask = '1;
    logic [NL-1:0] m_lines = '0;
    logic [31:0] m_word [NL];
    logic [NL-1:0] e_sd = '0, e_oe = '0;
    bit e_fs = 0, e_take = 0, e_under = 0, e_last = 0, e_even = 0;
    // frame period tracking
    bit per_en = 0;
    int bit_idx = 0, last_start = -1, frames_in = 0;
    bit prev_act = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(logic [31:0] w, int b, int s, int n, bit right);
        if (right) return (b >= s - n) ? w[s-1-b] : 1'b0;
        return (b < n) ? w[n-1-b] : 1'b0;
    endfunction

    task automatic model_advance();
        int slot, b, p;
        bit fa;
        if (m_pos == m_len - 1) begin
            m_slots = cfg_net ? int'(cfg_slots) : 1;
            m_sw    = int'(cfg_sw);
            m_ww    = (int'(cfg_ww) > m_sw) ? m_sw : int'(cfg_ww);
            m_fsw = cfg_fsw; m_early = cfg_early; m_inv = cfg_inv;
            m_sckinv = cfg_sckinv; m_right = cfg_right;
            m_mask = cfg_mask; m_lines = cfg_lines;
            m_len = m_slots * m_sw;
            m_pos = 0;
            frames_in++;
        end else m_pos++;
        slot = m_pos / m_sw;
        b    = m_pos % m_sw;
        e_take = 0; e_under = 0; e_last = 0;
        if (b == 0) begin
            m_act = m_mask[slot];
            for (int l = 0; l < NL; l++)
                m_word[l] = (m_act && word_valid) ? word_data[l*W +: W] : 32'h0;
            e_take  = m_act && word_valid;
            e_under = m_act && !word_valid;
            e_last  = (slot == m_slots - 1);
        end
        e_even = (slot % 2 == 0);
        for (int l = 0; l < NL; l++) begin
            e_oe[l] = m_act && m_lines[l];
            e_sd[l] = e_oe[l] && exp_bit(m_word[l], b, m_sw, m_ww, m_right);
        end
        p  = m_early ? (m_pos + 1) % m_len : m_pos;
        fa = m_fsw ? (p < m_sw) : (p == 0);
        e_fs = fa ^ m_inv;
    endtask

    task automatic check_outputs();
        string ts, tf;
        ts = !m_act ? "R9" : (m_right ? "R8" : "R7");
        tf = m_inv ? "R6" : (m_early ? "R5" : "R4");
        chk("R2", "sck", sck, 64'(m_phase ^ m_sckinv));
        chk(ts, "sd", sd, 64'(e_sd));
        chk(m_act ? "R10" : "R9", "oe", oe, 64'(e_oe));
        chk(tf, "fs", fs, 64'(e_fs));
        chk("R11", "take", take, 64'(e_take));
        chk("R11", "underrun", under, 64'(e_under));
        chk("R12", "last_slot", last, 64'(e_last));
        chk("R12", "even_slot", even, 64'(e_even));
    endtask

    task automatic strobe();
        bit act_now;
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        m_phase = ~m_phase;
        if (!m_phase) begin
            model_advance();
            check_outputs();
            bit_idx++;
            act_now = fs ^ m_inv;
            if (per_en && act_now && !prev_act) begin
                if (last_start >= 0 && frames_in >= 3)
                    chk("R3", "frame period", 64'(bit_idx - last_start), 64'(m_len));
                last_start = bit_idx;
            end
            prev_act = act_now;
        end else begin
            chk("R2", "sck", sck, 64'(m_phase ^ m_sckinv));
            chk("R11", "take pulse width", take, 64'(0));
        end
        repeat ($urandom % 3) begin
            @(negedge clk);
            chk("R2", "sd hold", sd, 64'(e_sd));
            chk("R12", "last pulse width", last, 64'(0));
        end
    endtask

    task automatic run_bits(int nbits, int valid_pct);
        for (int i = 0; i < 2 * nbits; i++) begin
            word_valid = (($urandom % 100) < valid_pct);
            for (int l = 0; l < NL; l++) word_data[l*W +: W] = $urandom;
            strobe();
        end
    endtask

    task automatic set_cfg(int sl, int sw, int ww, bit net, bit fw, bit er, bit iv,
                           bit ck, bit rt, logic [31:0] mk, logic [NL-1:0] ln);
        cfg_slots = 6'(sl); cfg_sw = 6'(sw); cfg_ww = 6'(ww); cfg_net = net;
        cfg_fsw = fw; cfg_early = er; cfg_inv = iv; cfg_sckinv = ck; cfg_right = rt;
        cfg_mask = mk; cfg_lines = ln;
    endtask

    task automatic phase_start();
        last_start = -1; frames_in = 0; prev_act = 1;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C));
        for (int l = 0; l < NL; l++) m_word[l] = '0;
        word_valid = 1'b0; word_data = '0;
        // left-justified network, slot 2 masked, some lines off
        set_cfg(4, 16, 12, 1, 1, 0, 0, 0, 0, 32'h0000_000B, 6'b101011);
        repeat (3) @(negedge clk);
        chk("R1", "sck in reset", sck, 64'(0));
        chk("R1", "fs in reset", fs, 64'(0));
        chk("R1", "sd/oe in reset", {sd, oe}, 64'(0));
        chk("R1", "flags in reset", {take, under, last, even}, 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "idle after reset", {sck, fs, sd, oe, take, under, last, even}, 64'(0));
        per_en = 1;
        phase_start(); run_bits(260, 100);
        // I2S-like: active-low, early, slot-long sync, inverted clock
        set_cfg(2, 32, 24, 1, 1, 1, 1, 1, 0, 32'h3, 6'b111111);
        phase_start(); run_bits(260, 100);
        // DSP with early one-bit sync
        set_cfg(8, 8, 8, 1, 0, 1, 0, 0, 0, 32'hFF, 6'b010101);
        phase_start(); run_bits(260, 100);
        // DSP with one-bit sync on the first bit
        set_cfg(6, 10, 10, 1, 0, 0, 0, 0, 0, 32'h2D, 6'b110011);
        phase_start(); run_bits(220, 100);
        // right-justified, word wider than slot in one part
        set_cfg(2, 32, 20, 1, 1, 0, 0, 0, 1, 32'h3, 6'b111111);
        phase_start(); run_bits(260, 100);
        set_cfg(3, 12, 30, 1, 1, 0, 0, 0, 1, 32'h7, 6'b111111);
        phase_start(); run_bits(200, 100);
        // normal mode: slot count ignored
        set_cfg(5, 24, 16, 0, 1, 0, 0, 0, 0, 32'h1, 6'b000111);
        phase_start(); run_bits(200, 100);
        // underruns
        set_cfg(4, 16, 16, 1, 1, 0, 0, 0, 0, 32'hF, 6'b111111);
        phase_start(); run_bits(300, 50);
        per_en = 0;
        // random configurations
        for (int k = 0; k < 30; k++) begin
            set_cfg(1 + $urandom % 8, 2 + $urandom % 31, 1 + $urandom % 32,
                    1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), $urandom, 6'($urandom));
            run_bits(120, 80);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule